// File: doc/BRIEF.md
# Vector Unsigned Right-Shift Lane Array

This block executes the unsigned shift-right-by-immediate group of vector instructions over a 128-bit register. Each request carries a 32-bit instruction word, a source vector and the current destination vector. The block decodes the instruction word into a lane width and a shift amount. It then shifts every lane of the source right logically. Depending on the opcode, it adds the rounding bit (the last bit shifted out) and adds the result into the matching destination lane.

A 7-bit immediate selects both the lane size and the shift. The position of the leading one in its upper four bits (immh) sets the lane width to 8, 16, 32 or 64 bits. The shift equals twice that width minus the whole 7-bit immediate, so it always lies between 1 and the lane width. A width bit in the instruction selects either a 64-bit or a 128-bit operation.

A request with `in_valid` high returns one clock later with `out_valid` high, the result vector and two flags. The flags report a malformed word or an unsupported combination of width and lane size. When either flag is set, the result is zero.

Top module: `vec_ursra_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. `result` and both flags are registered and belong to that request.
- R2: The instruction word is laid out as {bit31=0, bit30=Q, bits29:23=1011110, bits22:19=immh, bits18:16=immb, bits15:10=opcode, bits9:0 ignored}. The lane width is 8 << (index of the highest set bit of immh). The shift is 2*width - {immh,immb}.
- R3: Opcode 000001 (plain shift): each lane of the result is the source lane shifted right logically.
- R4: Opcode 001001 (rounding shift): each lane is the shifted value plus bit (shift-1) of the source lane, modulo the lane width.
- R5: Opcodes 000101 (shift-accumulate) and 001101 (rounding shift-accumulate): the shifted value from R3 or R4 is added to the destination lane, wrapping modulo the lane width.
- R6: When Q is 0 only the low 64 bits are processed, and result bits 127:64 are zero. When Q is 1 all 128 bits are processed.
- R7: immh equal to 0000 sets `err_decode` and forces the result to zero.
- R8: Q equal to 0 with immh bit 3 set sets `err_reserved` (and not `err_decode`) and forces the result to zero.
- R9: A word whose bit 31 or bits 29:23 differ from the pattern, or whose opcode is not one of the four above, sets `err_decode` and forces the result to zero. The two flags are never set together.
- R10: A shift equal to the lane width gives zero before rounding. The rounding shift then yields the lane's top bit.
- R11: While `rst` is high at a clock edge, `out_valid`, `result` and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Destination vector before the operation |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 128 | New destination value |
| err_decode | output | 1 | Malformed instruction word |
| err_reserved | output | 1 | 64-bit lanes requested in a 64-bit operation |

## Verification
The bench sweeps all 128 values of the 7-bit immediate, in both widths and all four opcodes. This covers every lane size, every legal shift including the full-width shift, and both error encodings. Each point runs with all-ones data, which shows carries out of rounding and accumulation, and with alternating bit patterns, which show misplaced lane boundaries and wrong shift counts. It also runs with pseudo-random data, so that the rounding bit is sampled at arbitrary positions. Malformed words with a bad fixed field or unknown opcode bits show whether the decode flag is kept apart from the reserved flag.

// File: rtl/usra_pkg.sv
package usra_pkg;
  localparam int INSN_W  = 32;
  localparam int N_SIZES = 4;

  localparam logic [6:0] FIXED_PAT = 7'b1011110;

  typedef enum logic [5:0] {
    OPC_SHR  = 6'b000001,
    OPC_SRA  = 6'b000101,
    OPC_RSHR = 6'b001001,
    OPC_RSRA = 6'b001101
  } opc_e;

  typedef struct packed {
    logic       q;
    logic [1:0] size_idx;
    logic [6:0] shift;
    logic       do_round;
    logic       do_acc;
    logic       dec_err;
    logic       rsv_err;
  } dec_t;
endpackage

// File: rtl/usra_decode.sv
module usra_decode
  import usra_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic [3:0] immh;
  logic [2:0] immb;
  logic [5:0] opc;
  logic [1:0] size;
  logic [7:0] twice;
  logic       fixed_ok;
  logic       opc_ok;
  logic       unused_regfields;

  assign unused_regfields = ^insn[9:0];

  always_comb begin
    immh     = insn[22:19];
    immb     = insn[18:16];
    opc      = insn[15:10];
    fixed_ok = !insn[31] && (insn[29:23] == FIXED_PAT);
    opc_ok   = (opc == OPC_SHR) || (opc == OPC_SRA) ||
               (opc == OPC_RSHR) || (opc == OPC_RSRA);
    if (immh[3])      size = 2'd3;
    else if (immh[2]) size = 2'd2;
    else if (immh[1]) size = 2'd1;
    else              size = 2'd0;
    twice        = 8'd16 << size;
    dec.size_idx = size;
    dec.shift    = 7'(twice - {1'b0, immh, immb});
    dec.q        = insn[30];
    dec.do_round = opc[3];
    dec.do_acc   = opc[2];
    dec.dec_err  = !fixed_ok || !opc_ok || (immh == 4'd0);
    dec.rsv_err  = fixed_ok && opc_ok && (immh != 4'd0) && !insn[30] && immh[3];
  end
endmodule

// File: rtl/usra_lane_bank.sv
module usra_lane_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic [6:0]       shift,
  input  logic             do_round,
  input  logic             do_acc,
  output logic [VEC_W-1:0] res
);
  localparam int N_LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    logic [LANE_W-1:0] x;
    logic [LANE_W-1:0] d;
    logic [LANE_W-1:0] shifted;
    logic [LANE_W-1:0] addend;
    logic [LANE_W-1:0] sum;
    logic              rbit;

    always_comb begin
      x       = src[i*LANE_W +: LANE_W];
      d       = dst[i*LANE_W +: LANE_W];
      shifted = LANE_W'({1'b0, x} >> shift);
      rbit    = do_round & 1'({x, 1'b0} >> shift);
      addend  = do_acc ? d : '0;
      sum     = shifted + {{(LANE_W-1){1'b0}}, rbit} + addend;
    end

    assign res[i*LANE_W +: LANE_W] = sum;
  end
endmodule

// File: rtl/vec_ursra_unit.sv
module vec_ursra_unit
  import usra_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [VEC_W-1:0]  dst_vec,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result,
  output logic              err_decode,
  output logic              err_reserved
);
  localparam int HALF_W = VEC_W / 2;

  dec_t             dec;
  logic [VEC_W-1:0] bank_res [N_SIZES];
  logic [VEC_W-1:0] sel;

  usra_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  for (genvar g = 0; g < N_SIZES; g++) begin : g_bank
    usra_lane_bank #(
      .VEC_W  (VEC_W),
      .LANE_W (8 << g)
    ) u_bank (
      .src      (src_vec),
      .dst      (dst_vec),
      .shift    (dec.shift),
      .do_round (dec.do_round),
      .do_acc   (dec.do_acc),
      .res      (bank_res[g])
    );
  end

  always_comb begin
    sel = bank_res[dec.size_idx];
    if (!dec.q) sel[VEC_W-1:HALF_W] = '0;
    if (dec.dec_err || dec.rsv_err) sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      err_decode   <= 1'b0;
      err_reserved <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      result       <= in_valid ? sel : '0;
      err_decode   <= in_valid & dec.dec_err;
      err_reserved <= in_valid & dec.rsv_err;
    end
  end
endmodule

// File: rtl/vec_ursra_unit_chk.sv
module vec_ursra_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [31:0]      insn,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             err_decode,
  input logic             err_reserved
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !insn[30]) |=> (result[VEC_W-1:VEC_W/2] == '0));
  assert_immh_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[22:19] == 4'd0) |=> err_decode);
  assert_error_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (err_decode || err_reserved) |-> (result == '0));
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(err_decode && err_reserved));
  assert_narrow_wide_lane_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !insn[30] && insn[22]) |=> (err_decode || err_reserved));
endmodule

bind vec_ursra_unit vec_ursra_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .insn         (insn),
  .out_valid    (out_valid),
  .result       (result),
  .err_decode   (err_decode),
  .err_reserved (err_reserved)
);

// File: tb/vec_ursra_unit_test.sv
`timescale 1ns/1ps
module vec_ursra_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] src_vec = '0;
  logic [127:0] dst_vec = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         err_decode;
  logic         err_reserved;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_ursra_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_vec(src_vec), .dst_vec(dst_vec), .out_valid(out_valid),
    .result(result), .err_decode(err_decode), .err_reserved(err_reserved)
  );

  function automatic logic [31:0] mk(input logic q, input logic [6:0] imm7, input logic [5:0] opc);
    return {1'b0, q, 7'b1011110, imm7, opc, 10'h155};
  endfunction

  // Reference model from R2..R6, R10
  function automatic logic [127:0] model(input logic q, input int imm7, input logic [5:0] opc,
                                         input logic [127:0] s, input logic [127:0] d);
    int e, sh, nl;
    logic [63:0] mask, x, y, r;
    logic [127:0] acc;
    e = (imm7 >= 64) ? 64 : (imm7 >= 32) ? 32 : (imm7 >= 16) ? 16 : 8;
    sh = 2 * e - imm7;
    mask = (e == 64) ? {64{1'b1}} : ((64'd1 << e) - 64'd1);
    nl = 128 / e;
    acc = '0;
    for (int i = 0; i < nl; i++) begin
      x = 64'(s >> (i * e)) & mask;
      y = 64'(d >> (i * e)) & mask;
      r = (sh >= 64) ? 64'd0 : (x >> sh);
      if (opc[3]) r = r + ((x >> (sh - 1)) & 64'd1);
      if (opc[2]) r = r + y;
      r = r & mask;
      acc = acc | (128'(r) << (i * e));
    end
    if (!q) acc[127:64] = '0;
    return acc;
  endfunction

  task automatic check(input string tag, input logic [127:0] er, input logic ed, input logic ers);
    checks++;
    if (!out_valid || result !== er || err_decode !== ed || err_reserved !== ers) begin
      errors++;
      $display("FAIL %s: actual v=%0b res=%h ed=%0b er=%0b expected v=1 res=%h ed=%0b er=%0b",
               tag, out_valid, result, err_decode, err_reserved, er, ed, ers);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [127:0] s, input logic [127:0] d,
                     input string tag, input logic [127:0] er, input logic ed, input logic ers);
    @(negedge clk);
    in_valid = 1'b1; insn = w; src_vec = s; dst_vec = d;
    @(negedge clk);
    check(tag, er, ed, ers);
  endtask

  initial begin
    logic [5:0] opcs [4];
    logic [127:0] pat_s [3];
    logic [127:0] pat_d [3];
    opcs[0] = 6'b000001; opcs[1] = 6'b000101; opcs[2] = 6'b001001; opcs[3] = 6'b001101;
    pat_s[0] = {128{1'b1}};
    pat_d[0] = {128{1'b1}};
    pat_s[1] = {32{4'hA}};
    pat_d[1] = {32{4'h5}};
    pat_s[2] = {$urandom(7), $urandom, $urandom, $urandom};
    pat_d[2] = {$urandom, $urandom, $urandom, $urandom};

    // R11: reset clears outputs even with a request pending
    in_valid = 1'b1; insn = mk(1'b1, 7'd9, 6'b000001); src_vec = pat_s[0];
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || err_decode !== 1'b0 || err_reserved !== 1'b0) begin
      errors++;
      $display("FAIL R11: actual v=%0b res=%h expected v=0 res=0", out_valid, result);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    // R2..R8, R10 sweep over every immediate, both widths, all opcodes
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < 4; o++) begin
        for (int qi = 0; qi < 2; qi++) begin
          for (int im = 0; im < 128; im++) begin
            logic ed, ers;
            logic [127:0] er;
            string tag;
            ed = (im < 8);
            ers = !ed && (qi == 0) && (im >= 64);
            er = (ed || ers) ? '0 : model(qi[0], im, opcs[o], pat_s[p], pat_d[p]);
            if (ed) tag = "R7";
            else if (ers) tag = "R8";
            else if (o == 0) tag = (qi == 0) ? "R2/R3/R6" : "R2/R3";
            else if (o == 2) tag = (qi == 0) ? "R2/R4/R6/R10" : "R2/R4/R10";
            else tag = (qi == 0) ? "R2/R5/R6" : "R2/R5";
            run(mk(qi[0], im[6:0], opcs[o]), pat_s[p], pat_d[p], tag, er, ed, ers);
          end
        end
      end
    end

    // R10: shift equal to lane width (imm7 = width) on 8-bit lanes, rounding -> top bit
    run(mk(1'b1, 7'd8, 6'b001001), {16{8'h80}}, '0, "R10", {16{8'h01}}, 1'b0, 1'b0);
    run(mk(1'b1, 7'd8, 6'b000001), {16{8'hFF}}, '0, "R10", '0, 1'b0, 1'b0);
    // R4: rounding carry on 16-bit lanes, shift 1 of 0xFFFF -> 0x8000
    run(mk(1'b1, 7'd31, 6'b001001), {8{16'hFFFF}}, '0, "R4", {8{16'h8000}}, 1'b0, 1'b0);
    // R5: wrap on accumulate, 64-bit lanes shift 64 round of top bit + all ones -> 0
    run(mk(1'b1, 7'd64, 6'b001101), {2{64'h8000_0000_0000_0000}}, {128{1'b1}}, "R5", '0, 1'b0, 1'b0);
    // R9: malformed words
    run(mk(1'b1, 7'd9, 6'b000001) | 32'h8000_0000, pat_s[0], pat_d[0], "R9", '0, 1'b1, 1'b0);
    run(mk(1'b1, 7'd9, 6'b000001) ^ 32'h0080_0000, pat_s[0], pat_d[0], "R9", '0, 1'b1, 1'b0);
    run(mk(1'b1, 7'd9, 6'b010001), pat_s[0], pat_d[0], "R9", '0, 1'b1, 1'b0);
    run(mk(1'b0, 7'd70, 6'b000011), pat_s[0], pat_d[0], "R9", '0, 1'b1, 1'b0);

    // R1: idle cycle clears out_valid
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual v=%0b expected v=0", out_valid);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule